// File: doc/BRIEF.md
# Framed Serial Register-Access Slave

This block lets an external serial master read and write a small internal byte-wide register array. The serial clock runs continuously. Bytes do not use a chip-select edge for framing. Each input byte begins with a one-cycle pulse on the receive strobe, followed by eight data bits on the next eight clock cycles. Each output byte begins with a one-cycle pulse on the transmit strobe, after which the block drives eight bits on the data-out line.

A transaction opens with two instruction bytes. The first is a register address. The second holds the transfer direction in its top bit and a burst length N in its lower seven bits. N data bytes follow: writes arrive on receive strobes, and reads leave on transmit strobes. The internal address steps after every byte. One input pin, the order select, fixes both the bit order on the wire and the direction of the burst. With order select at 0, bits are least-significant first and the address counts up. With order select at 1, bits are most-significant first and the address counts down, so the address byte is the top end of the burst.

The controller is a five-state machine:
- ST_ADDR waits for the address byte. The transition ADDR→CMD fires when the address byte has been collected.
- ST_CMD waits for the direction/count byte. It leaves on CMD→ADDR when N is zero, CMD→WRITE when the direction bit is 0, or CMD→READ when it is 1.
- ST_WRITE stores one byte per received word. It returns on WRITE→ADDR after the Nth byte.
- ST_READ loads one byte into the output shifter per transmit strobe. It moves on READ→DRAIN when the Nth byte has been loaded.
- ST_DRAIN waits until the last bit has left the output shifter. It then takes DRAIN→ADDR.

From any state, raising chip select forces ANY→ADDR.

Top module: `fsrs_slave`

## Requirements
- R1: After reset the block waits for an address byte. `busy`, `sdo_oe` and `sdo` are 0, and every register reads as 0x00.
- R2: An input byte is accepted on a rising edge where `rx_frame` is 1 and `cs_n` is 0. The next eight rising edges sample `sdi`. With `order_sel`=0 the first sampled bit is bit 0 (LSB first); with `order_sel`=1 it is bit 7 (MSB first).
- R3: The first byte of a transaction is the address; its bit 7 is ignored. In the second byte, bit 7 selects the direction (1 = read, 0 = write) and bits 6:0 give the count N.
- R4: A write burst stores exactly N bytes, starting at the address byte. The address increments modulo 128 after each byte when `order_sel`=0 and decrements modulo 128 when `order_sel`=1. The byte after the Nth is taken as a new address.
- R5: In a read burst, a rising edge with `tx_frame`=1 loads the register at the current address. That edge and the next seven each drive one bit on `sdo`, in the bit order of R2. `sdo_oe` is 1 for exactly those eight cycles. The address then steps as in R4.
- R6: `sdo_oe` is 0, and `sdo` is 0, whenever no read bit is being shifted out. This includes every write and instruction phase.
- R7: A count of N = 0 ends the transaction at once. `busy` stays 0, no data byte is expected, and the next byte is an address.
- R8: While `cs_n` is 1, the block abandons any partial byte, instruction or burst. It returns to waiting for an address and ignores both strobes.
- R9: A receive strobe that arrives while a byte is being collected discards the bits gathered so far and starts a new byte.
- R10: `busy` is 1 from the edge that accepts a command with N > 0. It stays 1 until the last write byte has been stored, or until the last read bit has been shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running serial clock; all sampling and driving on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and ignores strobes |
| order_sel | input | 1 | 0: LSB first, address counts up; 1: MSB first, address counts down |
| sdi | input | 1 | Serial data in |
| rx_frame | input | 1 | One-cycle strobe that starts an input byte |
| tx_frame | input | 1 | One-cycle strobe that starts an output byte during a read burst |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe | output | 1 | Enable for the external tri-state pad driver of `sdo` |
| busy | output | 1 | High while a write or read burst is in progress |

## Verification
The bench writes bursts that cross address 0x7F in both directions. A design that does not wrap, or that steps the wrong way for one order setting, would scatter the bytes, and the read-back would show it. It sends a zero-length command and then checks that the next byte is treated as an address. A block that waited for a data byte would write the wrong register. It also drops chip select in the middle of an instruction and in the middle of a burst, and restarts a byte with a second receive strobe. A design that kept stale state or stale bits would corrupt the next transaction. Each read byte is checked bit by bit, together with the eight-cycle output-enable window, so an off-by-one in the transmit timing or a reversed bit order is caught.

// File: rtl/fsrs_pkg.sv
package fsrs_pkg;

    typedef enum logic [2:0] {
        ST_ADDR  = 3'd0,
        ST_CMD   = 3'd1,
        ST_WRITE = 3'd2,
        ST_READ  = 3'd3,
        ST_DRAIN = 3'd4
    } fsm_state_t;

endpackage

// File: rtl/fsrs_rx_shift.sv
module fsrs_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              frame,
    input  logic              bit_in,
    input  logic              msb_first,
    output logic              done,
    output logic [DATA_W-1:0] data
);
    localparam int CW = $clog2(DATA_W);

    logic              active;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] sh_next;

    always_comb begin
        if (msb_first) begin
            sh_next = {sh[DATA_W-2:0], bit_in};
        end else begin
            sh_next = {bit_in, sh[DATA_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            done   <= 1'b0;
            data   <= '0;
        end else if (flush) begin
            active <= 1'b0;
            cnt    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (frame) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active) begin
                sh  <= sh_next;
                cnt <= cnt + 1'b1;
                if (cnt == CW'(DATA_W-1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    data   <= sh_next;
                end
            end
        end
    end

    // R2: a finished byte is only reported after a bit-collection cycle
    assert_done_after_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(active) && !$past(frame));

    // R8: flush clears collection and reporting
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !active && !done);

endmodule

// File: rtl/fsrs_tx_shift.sv
module fsrs_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              msb_first,
    output logic              sdo,
    output logic              oe
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam int IW = $clog2(DATA_W);

    logic [DATA_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     next_idx;
    logic [IW-1:0]     first_idx;

    always_comb begin
        first_idx = msb_first ? IW'(DATA_W-1) : '0;
        next_idx  = msb_first ? (IW'(DATA_W-1) - cnt[IW-1:0]) : cnt[IW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
            sdo <= 1'b0;
            oe  <= 1'b0;
        end else if (flush) begin
            cnt <= '0;
            sdo <= 1'b0;
            oe  <= 1'b0;
        end else if (load) begin
            sh  <= load_data;
            sdo <= load_data[first_idx];
            oe  <= 1'b1;
            cnt <= CW'(1);
        end else if (oe) begin
            if (cnt == CW'(DATA_W)) begin
                oe  <= 1'b0;
                sdo <= 1'b0;
                cnt <= '0;
            end else begin
                sdo <= sh[next_idx];
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5: the output window only opens on a load
    assert_oe_opens_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(load));

    // R6: the line is quiet while the driver is disabled
    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !sdo);

endmodule

// File: rtl/fsrs_regfile.sv
module fsrs_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];

    // R4: a written location holds the written byte afterwards
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/fsrs_slave.sv
module fsrs_slave
    import fsrs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = DATA_W - 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic order_sel,
    input  logic sdi,
    input  logic rx_frame,
    input  logic tx_frame,
    output logic sdo,
    output logic sdo_oe,
    output logic busy
);
    localparam int CNT_W = DATA_W - 1;

    fsm_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              rx_done;
    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic              tx_load;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic down);
        return down ? (a - 1'b1) : (a + 1'b1);
    endfunction

    fsrs_rx_shift #(.DATA_W(DATA_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cs_n),
        .frame     (rx_frame),
        .bit_in    (sdi),
        .msb_first (order_sel),
        .done      (rx_done),
        .data      (rx_data)
    );

    fsrs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (addr_q),
        .wdata (rx_data),
        .raddr (addr_q),
        .rdata (rd_data)
    );

    fsrs_tx_shift #(.DATA_W(DATA_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cs_n),
        .load      (tx_load),
        .load_data (rd_data),
        .msb_first (order_sel),
        .sdo       (sdo),
        .oe        (sdo_oe)
    );

    // Next-state and datapath control
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        cnt_d   = cnt_q;
        wr_en   = 1'b0;
        tx_load = 1'b0;
        unique case (state_q)
            ST_ADDR: begin
                if (rx_done) begin
                    addr_d  = rx_data[ADDR_W-1:0];
                    state_d = ST_CMD;
                end
            end
            ST_CMD: begin
                if (rx_done) begin
                    cnt_d = rx_data[CNT_W-1:0];
                    if (rx_data[CNT_W-1:0] == '0) begin
                        state_d = ST_ADDR;
                    end else if (rx_data[DATA_W-1]) begin
                        state_d = ST_READ;
                    end else begin
                        state_d = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (rx_done) begin
                    wr_en  = 1'b1;
                    addr_d = step_addr(addr_q, order_sel);
                    cnt_d  = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = ST_ADDR;
                    end
                end
            end
            ST_READ: begin
                if (tx_frame) begin
                    tx_load = 1'b1;
                    addr_d  = step_addr(addr_q, order_sel);
                    cnt_d   = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (!sdo_oe) begin
                    state_d = ST_ADDR;
                end
            end
            default: begin
                state_d = ST_ADDR;
            end
        endcase
        if (cs_n) begin
            state_d = ST_ADDR;
            wr_en   = 1'b0;
            tx_load = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ADDR;
            addr_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q == ST_WRITE) || (state_q == ST_READ) || (state_q == ST_DRAIN);
    end

    // R8: deselect aborts everything
    assert_cs_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state_q == ST_ADDR) && !sdo_oe);

    // R7: a zero count closes the transaction
    assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && rx_done && !cs_n && rx_data[CNT_W-1:0] == '0)
        |=> (state_q == ST_ADDR) && !busy);

    // R6: the driver is only enabled in a read burst
    assert_oe_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (state_q == ST_READ) || (state_q == ST_DRAIN));

    // R4: the burst address steps once per stored byte
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && rx_done && !cs_n)
        |=> addr_q == ($past(order_sel) ? $past(addr_q) - 1'b1 : $past(addr_q) + 1'b1));

    // R10: busy drops only at the last write byte or after draining
    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cs_n) || $past(state_q == ST_DRAIN && !sdo_oe)
                        || $past(state_q == ST_WRITE && rx_done && cnt_q == CNT_W'(1)));

endmodule

// File: tb/fsrs_slave_tb.sv
`timescale 1ns/1ps
module fsrs_slave_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic order_sel = 1'b0;
    logic sdi = 1'b0;
    logic rx_frame = 1'b0;
    logic tx_frame = 1'b0;
    logic sdo, sdo_oe, busy;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;
    logic [7:0] shadow [128];

    always #2.5 clk = ~clk;

    fsrs_slave dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .order_sel (order_sel),
        .sdi       (sdi),
        .rx_frame  (rx_frame),
        .tx_frame  (tx_frame),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .busy      (busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [6:0] nxt(input logic [6:0] a);
        return order_sel ? a - 7'd1 : a + 7'd1;
    endfunction

    // one framed input byte, bit order from order_sel (R2)
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_frame = 1'b1;
        @(negedge clk); rx_frame = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sdi = order_sel ? b[7-i] : b[i];
            @(negedge clk);
        end
        sdi = 1'b0;
    endtask

    // one framed output byte, checking the eight-cycle enable window (R5, R6)
    task automatic get_byte(output logic [7:0] b, output bit oe_ok);
        oe_ok = 1'b1;
        b = '0;
        @(negedge clk); tx_frame = 1'b1;
        @(negedge clk); tx_frame = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!sdo_oe) oe_ok = 1'b0;
            if (order_sel) b[7-i] = sdo; else b[i] = sdo;
            @(negedge clk);
        end
        if (sdo_oe || sdo) oe_ok = 1'b0;
    endtask

    task automatic write_burst(input logic [6:0] a, input int n, input logic [7:0] seed);
        logic [6:0] p = a;
        send_byte({1'b0, a});
        send_byte({1'b0, 7'(n)});
        @(negedge clk);
        check(busy == 1'b1, "R10 busy after write command", busy, 1);
        check(sdo_oe == 1'b0, "R6 no drive during write", sdo_oe, 0);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = seed + 8'(k * 37);
            send_byte(d);
            shadow[p] = d;
            p = nxt(p);
        end
        settle();
        check(busy == 1'b0, "R10 busy cleared after last write (R4)", busy, 0);
    endtask

    task automatic read_burst(input logic [6:0] a, input int n, input string tag);
        logic [6:0] p = a;
        logic [7:0] got;
        bit         ok;
        send_byte({1'b0, a});
        send_byte({1'b1, 7'(n)});
        @(negedge clk);
        check(busy == 1'b1, "R10 busy after read command (R3)", busy, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(got, ok);
            check(got == shadow[p], tag, got, shadow[p]);
            check(ok, "R5 eight-cycle output window", ok, 1);
            p = nxt(p);
        end
        check(busy == 1'b1, "R10 busy through drain", busy, 1);
        settle();
        check(busy == 1'b0, "R10 busy cleared after drain", busy, 0);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 busy at reset", busy, 0);
        check(sdo_oe == 1'b0, "R1 sdo_oe at reset", sdo_oe, 0);
        check(sdo == 1'b0, "R1 sdo at reset (R6)", sdo, 0);
        order_sel = 1'b0;
        read_burst(7'h00, 2, "R1 reset value");
        read_burst(7'h55, 1, "R1 reset value");
    endtask

    task automatic t_lsb_burst();
        order_sel = 1'b0;
        write_burst(7'h10, 5, 8'h3C);
        read_burst(7'h10, 5, "R4 R2 lsb-first burst read-back");
        read_burst(7'h12, 2, "R5 mid-burst start");
    endtask

    task automatic t_wrap_up();
        order_sel = 1'b0;
        write_burst(7'h7E, 4, 8'hA1);
        read_burst(7'h7E, 4, "R4 upward wrap");
    endtask

    task automatic t_msb_burst();
        order_sel = 1'b1;
        write_burst(7'h25, 4, 8'h81);
        read_burst(7'h25, 4, "R2 msb-first downward read-back");
        order_sel = 1'b0;
        read_burst(7'h22, 4, "R4 downward placement seen upward");
    endtask

    task automatic t_wrap_down();
        order_sel = 1'b1;
        write_burst(7'h01, 3, 8'h5E);
        order_sel = 1'b0;
        read_burst(7'h7F, 3, "R4 downward wrap");
    endtask

    task automatic t_zero_count();
        order_sel = 1'b0;
        send_byte(8'hB0);              // address with bit 7 set: ignored (R3)
        send_byte(8'h00);              // write, N = 0
        settle();
        check(busy == 1'b0, "R7 zero write count", busy, 0);
        send_byte(8'h30);
        send_byte(8'h80);              // read, N = 0
        settle();
        check(busy == 1'b0, "R7 zero read count", busy, 0);
        check(sdo_oe == 1'b0, "R7 no output on zero read", sdo_oe, 0);
        write_burst(7'h31, 1, 8'hE7);  // next byte is an address
        read_burst(7'h30, 3, "R7 following transaction");
    endtask

    task automatic t_cs_abort();
        order_sel = 1'b0;
        send_byte(8'h40);
        @(negedge clk); cs_n = 1'b1;
        send_byte(8'h02);              // ignored while deselected
        @(negedge clk); cs_n = 1'b0;
        write_burst(7'h41, 2, 8'h19);
        read_burst(7'h40, 3, "R8 abort inside instruction");
        send_byte(8'h50);
        send_byte(8'h03);
        send_byte(8'hC4);
        shadow[7'h50] = 8'hC4;
        @(negedge clk); cs_n = 1'b1;
        settle();
        check(busy == 1'b0, "R8 abort inside burst", busy, 0);
        send_byte(8'h77);              // ignored
        @(negedge clk); cs_n = 1'b0;
        read_burst(7'h50, 3, "R8 burst remainder untouched");
    endtask

    task automatic t_restart_frame();
        order_sel = 1'b0;
        @(negedge clk); rx_frame = 1'b1;
        @(negedge clk); rx_frame = 1'b0;
        for (int i = 0; i < 3; i++) begin
            sdi = 1'b1;
            @(negedge clk);
        end
        sdi = 1'b0;
        write_burst(7'h60, 1, 8'h2D);
        read_burst(7'h60, 1, "R9 restarted byte");
        order_sel = 1'b1;
        @(negedge clk); rx_frame = 1'b1;
        @(negedge clk); rx_frame = 1'b0;
        for (int i = 0; i < 5; i++) begin
            sdi = 1'b1;
            @(negedge clk);
        end
        sdi = 1'b0;
        write_burst(7'h65, 2, 8'h90);
        read_burst(7'h65, 2, "R9 restarted byte msb-first");
    endtask

    initial begin
        for (int i = 0; i < 128; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_lsb_burst();
        t_wrap_up();
        t_msb_burst();
        t_wrap_down();
        t_zero_count();
        t_cs_abort();
        t_restart_frame();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule